// File: doc/BRIEF.md
# Oversampled UART Frame Word Codec

This block lets a synchronous serial port whose bit clock runs at sixteen times a UART baud rate talk to an asynchronous serial line. Every UART bit time is carried as one 16-bit word, and each word is either all zeros or all ones. A character becomes a run of ten such words, sent as one synchronous frame. The first word is a zero start word. Eight data words follow, least significant bit first. The last word is an all-ones stop word.

The encoder accepts a byte through a valid/ready handshake. It then presents the ten words one at a time on a word output that has its own valid/ready handshake. The decoder collects received words in groups of ten and decides each bit by a majority vote over the 16 samples in its word. After the tenth word it delivers the rebuilt byte with a one-cycle strobe. A framing error flag goes with the byte when the start or stop word does not decode as expected. The two directions share nothing and run at the same time.

Top module: `uart_word_codec`

## Requirements
- R1: After reset `byteReady` is 1 and both `wordValid` and `rxByteValid` are 0. A reset in the middle of a frame abandons that frame in both directions.
- R2: A byte is taken on a clock edge where `byteValid` and `byteReady` are both 1. `byteReady` then stays 0, and `byteValid` has no effect, until the edge on which the tenth word is taken. `byteReady` is 1 again in the cycle after that edge.
- R3: The first word presented after a byte is taken is 0x0000. Words 2 to 9 carry data bits 0 to 7 in that order, with a 0 bit sent as 0x0000 and a 1 bit sent as 0xFFFF. For example, 0x62 gives 0000,0000,FFFF,0000,0000,0000,FFFF,FFFF,0000,FFFF.
- R4: The tenth word is 0xFFFF. A word is taken on an edge where `wordValid` and `wordReady` are both 1, and exactly ten words are presented for each byte.
- R5: While `wordValid` is 1 and `wordReady` is 0, `wordValid` stays 1 and `wordData` does not change.
- R6: The decoder counts the edges where `rxWordValid` is 1, in groups of ten. In the cycle after the tenth word it raises `rxByteValid` for exactly one cycle. Bit i of `rxByte` is the decoded value of word i+2.
- R7: A received word decodes as 1 only if at least 9 of its 16 bits are 1. A word with exactly 8 ones decodes as 0.
- R8: `rxFrameErr`, read while `rxByteValid` is 1, is 1 when the first word decodes as 1 or the tenth word decodes as 0. The byte is delivered in either case.
- R9: Cycles in which `rxWordValid` is 0 are ignored by the decoder, and gaps between words do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Byte offered to the encoder |
| byteData | input | 8 | Byte to encode |
| byteReady | output | 1 | Encoder idle and able to take a byte |
| wordValid | output | 1 | Encoded word present |
| wordData | output | 16 | Encoded word |
| wordReady | input | 1 | Downstream takes the word |
| rxWordValid | input | 1 | Received word present |
| rxWord | input | 16 | Received word |
| rxByteValid | output | 1 | One-cycle strobe: decoded byte available |
| rxByte | output | 8 | Decoded byte |
| rxFrameErr | output | 1 | Framing error for the delivered byte |

## Verification
The bench holds a word back with `wordReady` low and offers a second byte while a frame is being sent. A design that advanced without the handshake, or that took the second byte, would send wrong or extra words. It feeds words that have exactly eight ones, which a vote with the wrong threshold or a rounding error would decode as 1. It also feeds words with a few bits flipped, which a decoder that looked at a single sample would get wrong. Bad start and stop words are sent with the byte still checked, a reset is applied in the middle of a frame, and received words are spaced with idle gaps to catch a decoder that counts cycles instead of words.

// File: rtl/codec_pkg.sv
package codec_pkg;
  typedef struct packed {
    logic encLoad;
    logic encStep;
    logic decCapture;
    logic decFinish;
  } codecCtl_t;
endpackage

// File: rtl/codec_ctrl.sv
module codec_ctrl
  import codec_pkg::*;
#(
  parameter int FRAME_WORDS = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             wordReady,
  input  logic             rxWordValid,
  output logic             byteReady,
  output logic             wordValid,
  output logic [IDX_W-1:0] encIdx,
  output logic [IDX_W-1:0] decIdx,
  output codecCtl_t        ctl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

  logic encBusy;

  always_comb begin
    ctl.encLoad    = byteValid && !encBusy;
    ctl.encStep    = encBusy && wordReady;
    ctl.decCapture = rxWordValid;
    ctl.decFinish  = rxWordValid && (decIdx == LAST_IDX);
  end

  assign byteReady = !encBusy;
  assign wordValid = encBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encBusy <= 1'b0;
      encIdx  <= '0;
    end else if (ctl.encLoad) begin
      encBusy <= 1'b1;
      encIdx  <= '0;
    end else if (ctl.encStep) begin
      if (encIdx == LAST_IDX) begin
        encBusy <= 1'b0;
        encIdx  <= '0;
      end else begin
        encIdx <= encIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decIdx <= '0;
    end else if (ctl.decCapture) begin
      decIdx <= (decIdx == LAST_IDX) ? '0 : decIdx + 1'b1;
    end
  end
endmodule

// File: rtl/codec_datapath.sv
module codec_datapath
  import codec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DATA_BITS = 8,
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  codecCtl_t            ctl,
  input  logic [IDX_W-1:0]     encIdx,
  input  logic [IDX_W-1:0]     decIdx,
  input  logic [DATA_BITS-1:0] byteData,
  input  logic [WORD_W-1:0]    rxWord,
  output logic [WORD_W-1:0]    wordData,
  output logic                 rxByteValid,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxFrameErr
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] MAJ_MIN = CNT_W'(WORD_W / 2 + 1);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_BITS + 1);

  logic [DATA_BITS-1:0] byteHold;
  logic [DATA_BITS-1:0] bitAcc;
  logic                 startBad;
  logic [CNT_W-1:0]     onesCnt;
  logic                 bitNow;
  logic                 encBit;

  // Encoder side: pick the data bit for the word being presented
  always_ff @(posedge clk) begin
    if (!rstN) byteHold <= '0;
    else if (ctl.encLoad) byteHold <= byteData;
  end

  always_comb begin
    encBit = 1'b0;
    for (int i = 0; i < DATA_BITS; i++)
      if (encIdx == IDX_W'(i + 1)) encBit = byteHold[i];
  end

  always_comb begin
    if (encIdx == '0) wordData = '0;
    else if (encIdx == STOP_IDX) wordData = '1;
    else wordData = {WORD_W{encBit}};
  end

  // Decoder side: majority vote across the received word
  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < WORD_W; i++) onesCnt = onesCnt + CNT_W'(rxWord[i]);
  end
  assign bitNow = (onesCnt >= MAJ_MIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitAcc   <= '0;
      startBad <= 1'b0;
    end else if (ctl.decCapture) begin
      if (decIdx == '0) startBad <= bitNow;
      for (int i = 0; i < DATA_BITS; i++)
        if (decIdx == IDX_W'(i + 1)) bitAcc[i] <= bitNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByteValid <= 1'b0;
      rxByte      <= '0;
      rxFrameErr  <= 1'b0;
    end else begin
      rxByteValid <= ctl.decFinish;
      if (ctl.decFinish) begin
        rxByte     <= bitAcc;
        rxFrameErr <= startBad || !bitNow;
      end
    end
  end
endmodule

// File: rtl/uart_word_codec.sv
module uart_word_codec
  import codec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 byteValid,
  input  logic [DATA_BITS-1:0] byteData,
  output logic                 byteReady,
  output logic                 wordValid,
  output logic [WORD_W-1:0]    wordData,
  input  logic                 wordReady,
  input  logic                 rxWordValid,
  input  logic [WORD_W-1:0]    rxWord,
  output logic                 rxByteValid,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxFrameErr
);
  localparam int FRAME_WORDS = DATA_BITS + 2;
  localparam int IDX_W = $clog2(FRAME_WORDS);

  codecCtl_t        ctl;
  logic [IDX_W-1:0] encIdx;
  logic [IDX_W-1:0] decIdx;

  codec_ctrl #(.FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .wordReady(wordReady),
    .rxWordValid(rxWordValid), .byteReady(byteReady), .wordValid(wordValid),
    .encIdx(encIdx), .decIdx(decIdx), .ctl(ctl)
  );

  codec_datapath #(.WORD_W(WORD_W), .DATA_BITS(DATA_BITS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .encIdx(encIdx), .decIdx(decIdx),
    .byteData(byteData), .rxWord(rxWord), .wordData(wordData),
    .rxByteValid(rxByteValid), .rxByte(rxByte), .rxFrameErr(rxFrameErr)
  );
endmodule

// File: rtl/codec_chk.sv
module codec_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic              byteReady,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordData,
  input logic              wordReady,
  input logic              rxByteValid
);
  // R2
  idle_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> !wordValid);

  // R3
  start_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteReady) |=> (wordValid && wordData == '0));

  // R3
  word_solid_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (wordData == '0 || wordData == '1));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> (wordValid && $stable(wordData)));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxByteValid |=> !rxByteValid);
endmodule

bind uart_word_codec codec_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteReady(byteReady),
  .wordValid(wordValid), .wordData(wordData), .wordReady(wordReady),
  .rxByteValid(rxByteValid)
);

// File: tb/tb_uart_word_codec.sv
module tb_uart_word_codec;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteReady, wordValid, wordReady = 1'b0;
  logic [15:0] wordData;
  logic rxWordValid = 1'b0;
  logic [15:0] rxWord = '0;
  logic rxByteValid, rxFrameErr;
  logic [7:0] rxByte;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  uart_word_codec dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .wordValid(wordValid), .wordData(wordData),
    .wordReady(wordReady), .rxWordValid(rxWordValid), .rxWord(rxWord),
    .rxByteValid(rxByteValid), .rxByte(rxByte), .rxFrameErr(rxFrameErr)
  );

  typedef struct packed {
    logic [7:0]  b;
    logic [15:0] noise;
    logic [15:0] startW;
    logic [15:0] stopW;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h62, 16'h0000, 16'h0000, 16'hFFFF},
    '{8'hA5, 16'h0101, 16'h0000, 16'hFFFF},
    '{8'h00, 16'h7F00, 16'h0000, 16'hFFFF},
    '{8'hFF, 16'h00FF, 16'h0000, 16'hFFFF},
    '{8'h3C, 16'h0000, 16'hFFFF, 16'hFFFF},
    '{8'h81, 16'h0000, 16'h0000, 16'h00FF},
    '{8'h5A, 16'h0000, 16'h0007, 16'hFFF0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [7:0] b, input int k);
    if (k == 0) return 16'h0000;
    if (k == 9) return 16'hFFFF;
    return b[k-1] ? 16'hFFFF : 16'h0000;
  endfunction

  function automatic logic vote(input logic [15:0] w);
    return $countones(w) >= 9;
  endfunction

  // Send one byte through the encoder, stalling on word 3 and offering a stray byte on word 5
  task automatic encode(input logic [7:0] b);
    @(negedge clk);
    check("R2 ready before load", byteReady, 1);
    byteValid = 1'b1; byteData = b;
    @(posedge clk); @(negedge clk);
    byteValid = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (k == 3) begin
        wordReady = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R5 held valid", wordValid, 1);
      end
      if (k == 5) begin byteValid = 1'b1; byteData = ~b; end
      check((k == 9) ? "R4 stop word" : "R3 word", wordData, expWord(b, k));
      check("R2 busy not ready", byteReady, 0);
      wordReady = 1'b1;
      @(posedge clk); @(negedge clk);
      wordReady = 1'b0; byteValid = 1'b0;
    end
    check("R2 ready after last", byteReady, 1);
    check("R4 no extra word", wordValid, 0);
  endtask

  // Feed ten words to the decoder with an idle gap after word 4
  task automatic decode(input logic [15:0] w [10], input logic [7:0] eb, input logic ee);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k > 0) check("R6 no early strobe", rxByteValid, 0);
      rxWordValid = 1'b1; rxWord = w[k];
      @(posedge clk);
      if (k == 4) begin
        @(negedge clk); rxWordValid = 1'b0; rxWord = 16'hFFFF;
        @(posedge clk);
      end
    end
    @(negedge clk);
    rxWordValid = 1'b0;
    check("R6 strobe", rxByteValid, 1);
    check("R6 R7 R9 byte", rxByte, eb);
    check("R8 frame error", rxFrameErr, ee);
    @(negedge clk);
    check("R6 strobe one cycle", rxByteValid, 0);
  endtask

  initial begin
    logic [15:0] words [10];
    logic [7:0] eb;
    repeat (3) @(negedge clk);
    check("R1 ready", byteReady, 1);
    check("R1 word valid", wordValid, 0);
    check("R1 rx valid", rxByteValid, 0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      encode(VECS[v].b);
      words[0] = VECS[v].startW;
      words[9] = VECS[v].stopW;
      eb = '0;
      for (int k = 1; k < 9; k++) begin
        words[k] = expWord(VECS[v].b, k) ^ VECS[v].noise;
        eb[k-1] = vote(words[k]);
      end
      decode(words, eb, vote(words[0]) || !vote(words[9]));
    end

    // R7 tie: eight ones decodes as zero
    for (int k = 0; k < 10; k++) words[k] = expWord(8'hFF, k);
    words[3] = 16'hF0F0;
    decode(words, 8'hFB, 1'b0);

    // R1 reset mid-frame in both directions
    @(negedge clk);
    byteValid = 1'b1; byteData = 8'h11;
    rxWordValid = 1'b1; rxWord = 16'hFFFF;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    byteValid = 1'b0; rxWordValid = 1'b0; rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    check("R1 reset ready", byteReady, 1);
    check("R1 reset word valid", wordValid, 0);
    for (int k = 0; k < 10; k++) words[k] = expWord(8'hC3, k);
    decode(words, 8'hC3, 1'b0);
    encode(8'h96);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule